// File: doc/BRIEF.md
# DRAM ECC Error Capture Registers

This block sits beside a DRAM controller's ECC checker and keeps a sticky record of memory faults. Each access that fails the ECC check arrives as a one-cycle pulse, either correctable (single bit) or uncorrectable (multi bit), together with the failing cache-line address, the channel, the 8-bit syndrome and a requester type code. Three further pulse inputs report a refresh timeout, a lock error on a non-DRAM target and a thermal sensor event. Each event sets its own status bit, which stays set until software writes a one to it.

The details of one error are held at a time. The first error to arrive is logged, and an uncorrectable error replaces the details of a logged correctable one. Nothing else overwrites them while an error is pending. Software reads the fields through a simple register port and clears the status afterwards.

Three report outputs each carry the OR of the status bits that a mask of their own enables. The first path can report every event class. The other two can report only the two ECC classes. These outputs are levels and stay high while an enabled status bit is set.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and the three report outputs are low.
- R2: The status register at offset 0x00 holds the correctable flag in bit 0, the uncorrectable flag in bit 1, refresh timeout in bit 8, lock error in bit 9 and thermal event in bit 11. The other bits read zero. A pulse on an event input sets its bit, and the bit reads as set from the cycle after the pulse.
- R3: Writing to offset 0x00 clears each status bit where the write data holds a one. Bits where the data holds a zero keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A correctable error that arrives while no ECC error is pending captures its details. Offset 0x04 holds line address bits 31:7 in bits 31:7, zeros in bits 6:1 and the channel in bit 0. Offset 0x08 holds address bit 32 in bit 0 and zeros elsewhere. Offset 0x0C holds the syndrome. Offset 0x10 holds the requester type, where 0 means a processor memory read.
- R6: An uncorrectable error that arrives while no uncorrectable error is pending captures its details and overwrites any correctable ones. When both pulses come in the same cycle, the uncorrectable details are kept.
- R7: A correctable error that arrives while either ECC flag is set leaves the captured fields unchanged. An uncorrectable error that arrives while the uncorrectable flag is set also leaves them unchanged. This decision uses the status value held before any write in the same cycle.
- R8: Mask 0 at offset 0x14 stores only bits 0, 1, 8, 9 and 11. Masks 1 and 2, at offsets 0x18 and 0x1C, store only bits 0 and 1. All other bits read zero.
- R9: Each report output k is high exactly when some status bit is set and enabled in mask k.
- R10: A read of an offset outside the map returns zero. Writes to unmapped or read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ce_pulse | input | 1 | Correctable ECC error |
| ue_pulse | input | 1 | Uncorrectable ECC error |
| err_line | input | 26 | Failing address bits 32:7 |
| err_chan | input | 1 | Failing channel |
| err_syn | input | 8 | ECC syndrome |
| err_req | input | 8 | Requester type code |
| refresh_to | input | 1 | Refresh timeout event |
| lock_err | input | 1 | Non-DRAM lock error event |
| thermal_evt | input | 1 | Thermal sensor event |
| rpt0 | output | 1 | Report path 0 (all classes) |
| rpt1 | output | 1 | Report path 1 (ECC classes) |
| rpt2 | output | 1 | Report path 2 (ECC classes) |

## Verification
The assertions assume that the event inputs are known and free of glitches after reset. They also assume that the address, channel, syndrome and requester fields are valid in the same cycle as an ECC pulse, since the capture checks compare the stored syndrome with the value that was on the input. The bench keeps to these assumptions. It changes every input only on the falling clock edge, holds the error fields steady for the whole cycle in which a pulse is high, and drops each pulse after exactly one cycle unless a test is aimed at a same-cycle collision.

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ce_pulse,
  input  logic          ue_pulse,
  input  logic [25:0]   err_line,
  input  logic          err_chan,
  input  logic [7:0]    err_syn,
  input  logic [7:0]    err_req,
  input  logic          refresh_to,
  input  logic          lock_err,
  input  logic          thermal_evt,
  output logic          rpt0,
  output logic          rpt1,
  output logic          rpt2
);
  localparam logic [AW-1:0] OFF_STAT = AW'(8'h00);
  localparam logic [AW-1:0] OFF_ADDR = AW'(8'h04);
  localparam logic [AW-1:0] OFF_AHI  = AW'(8'h08);
  localparam logic [AW-1:0] OFF_SYN  = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_REQ  = AW'(8'h10);
  localparam logic [AW-1:0] OFF_MSK0 = AW'(8'h14);
  localparam logic [AW-1:0] OFF_MSK1 = AW'(8'h18);
  localparam logic [AW-1:0] OFF_MSK2 = AW'(8'h1C);
  localparam logic [15:0] STAT_BITS = 16'h0B03;
  localparam logic [15:0] ECC_BITS  = 16'h0003;

  logic [15:0] stat_q, msk0_q, msk1_q, msk2_q;
  logic [25:0] line_q;
  logic        chan_q;
  logic [7:0]  syn_q, req_q;

  logic [15:0] evt, clr;
  logic        cap_ue, cap_ce;

  assign evt = {4'b0, thermal_evt, 1'b0, lock_err, refresh_to, 6'b0, ue_pulse, ce_pulse};
  assign clr = (reg_wr && reg_addr == OFF_STAT) ? reg_wdata[15:0] : 16'h0;

  assign cap_ue = ue_pulse && !stat_q[1];
  assign cap_ce = ce_pulse && !ue_pulse && !stat_q[0] && !stat_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      msk0_q <= '0;
      msk1_q <= '0;
      msk2_q <= '0;
      line_q <= '0;
      chan_q <= 1'b0;
      syn_q  <= '0;
      req_q  <= '0;
    end else begin
      stat_q <= ((stat_q & ~clr) | evt) & STAT_BITS;
      if (reg_wr && reg_addr == OFF_MSK0) msk0_q <= reg_wdata[15:0] & STAT_BITS;
      if (reg_wr && reg_addr == OFF_MSK1) msk1_q <= reg_wdata[15:0] & ECC_BITS;
      if (reg_wr && reg_addr == OFF_MSK2) msk2_q <= reg_wdata[15:0] & ECC_BITS;
      if (cap_ue || cap_ce) begin
        line_q <= err_line;
        chan_q <= err_chan;
        syn_q  <= err_syn;
        req_q  <= err_req;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_STAT: reg_rdata = {16'h0, stat_q};
      OFF_ADDR: reg_rdata = {line_q[24:0], 6'b0, chan_q};
      OFF_AHI:  reg_rdata = {31'h0, line_q[25]};
      OFF_SYN:  reg_rdata = {24'h0, syn_q};
      OFF_REQ:  reg_rdata = {24'h0, req_q};
      OFF_MSK0: reg_rdata = {16'h0, msk0_q};
      OFF_MSK1: reg_rdata = {16'h0, msk1_q};
      OFF_MSK2: reg_rdata = {16'h0, msk2_q};
      default:  reg_rdata = 32'h0;
    endcase
  end

  assign rpt0 = |(stat_q & msk0_q);
  assign rpt1 = |(stat_q & msk1_q);
  assign rpt2 = |(stat_q & msk2_q);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_pulse |=> stat_q[0]);

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_STAT && reg_wdata[1] && !ue_pulse) |=> !stat_q[1]);

  assert_ue_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_pulse && !stat_q[1]) |=> syn_q == $past(err_syn));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[1] |=> ($stable(syn_q) && $stable(line_q) && $stable(chan_q)));

  assert_ecc_paths_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt1 || rpt2) |-> (stat_q[0] || stat_q[1]));
endmodule

// File: tb/ecc_err_log_tb_top.sv
module ecc_err_log_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ce_pulse = 0, ue_pulse = 0, err_chan = 0;
  logic [25:0] err_line = '0;
  logic [7:0] err_syn = '0, err_req = '0;
  logic refresh_to = 0, lock_err = 0, thermal_evt = 0;
  logic rpt0, rpt1, rpt2;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ecc_err_log #(.AW(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ce_pulse(ce_pulse),
    .ue_pulse(ue_pulse), .err_line(err_line), .err_chan(err_chan),
    .err_syn(err_syn), .err_req(err_req), .refresh_to(refresh_to),
    .lock_err(lock_err), .thermal_evt(thermal_evt),
    .rpt0(rpt0), .rpt1(rpt1), .rpt2(rpt2));

  // {line[25:0], chan, syn[7:0], req[7:0], exp_addr[31:0], exp_hi}
  localparam int NV = 4;
  localparam logic [75:0] VEC [NV] = '{
    {26'h0000001, 1'b0, 8'h11, 8'h00, 32'h00000080, 1'b0},
    {26'h2000000, 1'b1, 8'hA5, 8'h03, 32'h00000001, 1'b1},
    {26'h1FFFFFF, 1'b1, 8'hFF, 8'h07, 32'hFFFFFF81, 1'b0},
    {26'h0ABCDEF, 1'b0, 8'h3C, 8'h01, 32'h55E6F780, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic err(input bit ce, input bit ue, input logic [25:0] line,
                     input bit ch, input logic [7:0] syn, input logic [7:0] rq);
    ce_pulse = ce; ue_pulse = ue; err_line = line; err_chan = ch;
    err_syn = syn; err_req = rq;
    @(negedge clk);
    ce_pulse = 0; ue_pulse = 0;
  endtask

  task automatic chk_rpt(input string tag, input logic [2:0] exp);
    #1;
    chk(tag, {29'h0, rpt2, rpt1, rpt0}, {29'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int o = 0; o < 32; o += 4) rd("R1 reset read", 5'(o), 32'h0);
    chk_rpt("R1 reset outputs", 3'b000);

    // R5 table of first-error captures
    for (int i = 0; i < NV; i++) begin
      wr(5'h00, 32'hFFFF);
      err(1, 0, VEC[i][75:50], VEC[i][49], VEC[i][48:41], VEC[i][40:33]);
      rd("R2 ce flag bit0", 5'h00, 32'h1);
      rd("R5 address reg", 5'h04, VEC[i][32:1]);
      rd("R5 address bit32", 5'h08, {31'h0, VEC[i][0]});
      rd("R5 syndrome", 5'h0C, {24'h0, VEC[i][48:41]});
      rd("R5 requester", 5'h10, {24'h0, VEC[i][40:33]});
    end

    // R6 UE overwrites CE
    wr(5'h00, 32'hFFFF);
    err(1, 0, 26'h0000010, 0, 8'h11, 8'h00);
    err(0, 1, 26'h0000020, 1, 8'h22, 8'h05);
    rd("R6 both flags", 5'h00, 32'h3);
    rd("R6 syndrome replaced", 5'h0C, 32'h22);
    rd("R6 address replaced", 5'h04, 32'h00001001);
    rd("R6 requester replaced", 5'h10, 32'h05);

    // R7 no overwrite while UE pending
    err(1, 0, 26'h0000030, 0, 8'h33, 8'h00);
    rd("R7 ce after ue", 5'h0C, 32'h22);
    err(0, 1, 26'h0000040, 0, 8'h44, 8'h00);
    rd("R7 ue after ue", 5'h0C, 32'h22);
    rd("R7 addr kept", 5'h04, 32'h00001001);

    // R7 CE while CE pending
    wr(5'h00, 32'hFFFF);
    err(1, 0, 26'h0000050, 0, 8'h55, 8'h00);
    err(1, 0, 26'h0000060, 1, 8'h66, 8'h00);
    rd("R7 ce after ce", 5'h0C, 32'h55);
    rd("R7 ce after ce addr", 5'h04, 32'h00002800);

    // R6 simultaneous CE and UE
    wr(5'h00, 32'hFFFF);
    err(1, 1, 26'h0000070, 1, 8'h77, 8'h00);
    rd("R6 simultaneous flags", 5'h00, 32'h3);
    rd("R6 simultaneous syn", 5'h0C, 32'h77);

    // R3 write-one-to-clear
    wr(5'h00, 32'h0001);
    rd("R3 clear bit0 only", 5'h00, 32'h2);
    wr(5'h00, 32'h0000);
    rd("R3 zero write keeps", 5'h00, 32'h2);
    wr(5'h00, 32'h0002);
    rd("R3 clear bit1", 5'h00, 32'h0);

    // R2 other event bits
    refresh_to = 1; lock_err = 1; thermal_evt = 1;
    @(negedge clk);
    refresh_to = 0; lock_err = 0; thermal_evt = 0;
    rd("R2 misc events", 5'h00, 32'h0B00);
    wr(5'h00, 32'hFFFF);
    rd("R2 cleared", 5'h00, 32'h0);

    // R4 set wins over clear
    reg_wr = 1; reg_addr = 5'h00; reg_wdata = 32'h0001; ce_pulse = 1;
    err_syn = 8'h99;
    @(negedge clk);
    reg_wr = 0; ce_pulse = 0;
    rd("R4 set wins", 5'h00, 32'h1);
    wr(5'h00, 32'hFFFF);

    // R8 masks
    wr(5'h14, 32'hFFFFFFFF);
    rd("R8 mask0 bits", 5'h14, 32'h0B03);
    wr(5'h18, 32'hFFFFFFFF);
    rd("R8 mask1 bits", 5'h18, 32'h3);
    wr(5'h1C, 32'hFFFFFFFF);
    rd("R8 mask2 bits", 5'h1C, 32'h3);

    // R9 report paths
    wr(5'h14, 32'h0100);
    wr(5'h18, 32'h0002);
    wr(5'h1C, 32'h0001);
    chk_rpt("R9 idle", 3'b000);
    refresh_to = 1; @(negedge clk); refresh_to = 0;
    chk_rpt("R9 refresh to path0", 3'b001);
    err(1, 0, 26'h0, 0, 8'h01, 8'h00);
    chk_rpt("R9 ce to path2", 3'b101);
    err(0, 1, 26'h0, 0, 8'h02, 8'h00);
    chk_rpt("R9 ue to path1", 3'b111);
    wr(5'h00, 32'h0101);
    chk_rpt("R9 after partial clear", 3'b010);
    wr(5'h00, 32'hFFFF);
    chk_rpt("R9 cleared", 3'b000);

    // R10 unmapped and read-only
    wr(5'h0C, 32'hFFFFFFFF);
    rd("R10 ro syndrome", 5'h0C, 32'h02);
    wr(5'h02, 32'hFFFFFFFF);
    rd("R10 unmapped read", 5'h02, 32'h0);
    rd("R10 status untouched", 5'h00, 32'h0);

    // R1 reset while populated
    err(0, 1, 26'h3FFFFFF, 1, 8'hEE, 8'h07);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    rd("R1 status after reset", 5'h00, 32'h0);
    rd("R1 addr after reset", 5'h04, 32'h0);
    rd("R1 mask0 after reset", 5'h14, 32'h0);
    chk_rpt("R1 outputs after reset", 3'b000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule